// File: doc/BRIEF.md
# Synthesizer Control Register Bank

This block holds the digital configuration of a PLL frequency synthesizer. It has four byte-wide registers behind a simple parallel bus (address, write data, write strobe, read strobe, read data). From them it drives a 10-bit feedback divider ratio, a 5-bit reference prescaler factor and a 2-bit output drive current code to the analog side.

Some register writes also start a VCO calibration. The block issues a single-cycle start pulse on those writes, and a mode bit decides which writes count. The upper two divider bits are staged. A write to them reaches the divider output only on the next write that starts a calibration, so a hop is written high byte first, then low byte. The block also produces the RF output enable. It either follows a synchronized lock-detect input or is forced on.

Top module: `synth_cfg_bank`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, and `fdiv_ratio`, `ref_div`, `buf_cur`, `cal_start`, `rf_en` and `rdata` are all 0.
- R2: A read with `rd_en` returns the addressed register on `rdata` one clock later. Address 0 holds 8 bits, address 1 holds bits [1:0], address 2 holds bits [4:0] and address 3 holds bits [3:0]. Bits that are not implemented are dropped on write and read back as 0.
- R3: Addresses 4 and above read 0x00. Writes to them change no output and start no calibration.
- R4: `ref_div` equals bits [4:0] of address 2. `buf_cur` equals bits [1:0] of address 3.
- R5: `fdiv_ratio` is {applied high bits, address 0}. A write to address 1 changes only the staged high bits, and `fdiv_ratio` does not move until the next write that starts a calibration copies them over.
- R6: With address 3 bit 2 at 0, only a write to address 0 starts a calibration. `cal_start` is high for exactly the one cycle after the write edge.
- R7: With address 3 bit 2 at 1, a write to address 2 also starts a calibration and also applies the staged high divider bits.
- R8: Writes to address 1 or address 3, reads, and idle cycles never raise `cal_start`.
- R9: With address 3 bit 3 at 0, `rf_en` follows `lock_in` through a two-flop synchronizer. It changes on the second rising clock edge after `lock_in` changes.
- R10: With address 3 bit 3 at 1, `rf_en` is 1 whatever the level of `lock_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| lock_in | input | 1 | Asynchronous lock-detect level |
| fdiv_ratio | output | 10 | Applied feedback divider ratio |
| ref_div | output | 5 | Reference prescaler factor |
| buf_cur | output | 2 | Output buffer current code |
| cal_start | output | 1 | One-cycle calibration start pulse |
| rf_en | output | 1 | RF output enable |

## Verification
A corrupted staged or applied divider byte shows on `fdiv_ratio` right after the calibrating write that should have fixed it, one edge after the strobe. A wrong mode bit shows as a missing or extra `cal_start` on the cycle after a write to address 2. A fault in the lock path shows on `rf_en` two edges after a `lock_in` change, or at once when the force bit is set. Masking faults show on the readback one cycle after `rd_en`.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;
    localparam int DATA_W   = 8;
    localparam int FDIV_W   = 10;
    localparam int FDIV_HI_W = FDIV_W - DATA_W;
    localparam int RDIV_W   = 5;
    localparam int CUR_W    = 2;
    localparam int NUM_REGS = 4;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef enum logic [IDX_W-1:0] {
        IDX_FDIV_LO = 2'd0,
        IDX_FDIV_HI = 2'd1,
        IDX_RDIV    = 2'd2,
        IDX_CTRL    = 2'd3
    } reg_idx_t;

    typedef struct packed {
        logic             force_rf;
        logic             cal_any;
        logic [CUR_W-1:0] cur;
    } gen_ctrl_t;

    localparam int CTRL_W = $bits(gen_ctrl_t);

    function automatic logic [DATA_W-1:0] widen_hi(input logic [FDIV_HI_W-1:0] v);
        return DATA_W'(v);
    endfunction

    function automatic logic [DATA_W-1:0] widen_rdiv(input logic [RDIV_W-1:0] v);
        return DATA_W'(v);
    endfunction

    function automatic logic [DATA_W-1:0] widen_ctrl(input gen_ctrl_t v);
        return DATA_W'(v);
    endfunction
endpackage

// File: rtl/synth_cal_trig.sv
`timescale 1ns/1ps
module synth_cal_trig
    import synth_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_hit,
    input  reg_idx_t idx,
    input  logic     cal_any,
    output logic     cal_fire,
    output logic     cal_start
);
    always_comb begin
        cal_fire = 1'b0;
        if (wr_hit) begin
            unique case (idx)
                IDX_FDIV_LO: cal_fire = 1'b1;
                IDX_RDIV:    cal_fire = cal_any;
                default:     cal_fire = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cal_start <= 1'b0;
        else     cal_start <= cal_fire;
    end
endmodule

// File: rtl/synth_lock_gate.sv
`timescale 1ns/1ps
module synth_lock_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_in,
    input  logic force_rf,
    output logic rf_en
);
    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= lock_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], lock_in};
            end
        end
    endgenerate

    assign rf_en = force_rf | sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/synth_cfg_regs.sv
`timescale 1ns/1ps
module synth_cfg_regs
    import synth_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hit,
    input  logic                 rd_en,
    input  logic                 rd_hit,
    input  reg_idx_t             idx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 cal_fire,
    output logic [FDIV_W-1:0]    fdiv_ratio,
    output logic [RDIV_W-1:0]    ref_div,
    output gen_ctrl_t            ctrl,
    output logic [DATA_W-1:0]    rdata
);
    logic [DATA_W-1:0]    lo_q;
    logic [FDIV_HI_W-1:0] hi_stage_q;
    logic [FDIV_HI_W-1:0] hi_act_q;
    logic [RDIV_W-1:0]    rdiv_q;
    gen_ctrl_t            ctrl_q;
    logic [DATA_W-1:0]    rd_mux;

    always_comb begin
        unique case (idx)
            IDX_FDIV_LO: rd_mux = lo_q;
            IDX_FDIV_HI: rd_mux = widen_hi(hi_stage_q);
            IDX_RDIV:    rd_mux = widen_rdiv(rdiv_q);
            default:     rd_mux = widen_ctrl(ctrl_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q       <= '0;
            hi_stage_q <= '0;
            hi_act_q   <= '0;
            rdiv_q     <= '0;
            ctrl_q     <= '0;
            rdata      <= '0;
        end else begin
            if (wr_hit) begin
                unique case (idx)
                    IDX_FDIV_LO: lo_q       <= wdata;
                    IDX_FDIV_HI: hi_stage_q <= wdata[FDIV_HI_W-1:0];
                    IDX_RDIV:    rdiv_q     <= wdata[RDIV_W-1:0];
                    default:     ctrl_q     <= gen_ctrl_t'(wdata[CTRL_W-1:0]);
                endcase
            end
            if (cal_fire) hi_act_q <= hi_stage_q;
            if (rd_en)    rdata    <= rd_hit ? rd_mux : '0;
        end
    end

    assign fdiv_ratio = {hi_act_q, lo_q};
    assign ref_div    = rdiv_q;
    assign ctrl       = ctrl_q;
endmodule

// File: rtl/synth_cfg_bank.sv
`timescale 1ns/1ps
module synth_cfg_bank
    import synth_cfg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic              lock_in,
    output logic [9:0]        fdiv_ratio,
    output logic [4:0]        ref_div,
    output logic [1:0]        buf_cur,
    output logic              cal_start,
    output logic              rf_en
);
    logic      in_range;
    logic      wr_hit;
    reg_idx_t  idx;
    logic      cal_fire;
    gen_ctrl_t ctrl;
    logic      cal_mode_w;
    logic      force_w;

    assign in_range   = (addr < ADDR_W'(NUM_REGS));
    assign wr_hit     = wr_en & in_range;
    assign idx        = reg_idx_t'(addr[IDX_W-1:0]);
    assign cal_mode_w = ctrl.cal_any;
    assign force_w    = ctrl.force_rf;
    assign buf_cur    = ctrl.cur;

    synth_cal_trig u_trig (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_hit),
        .idx       (idx),
        .cal_any   (cal_mode_w),
        .cal_fire  (cal_fire),
        .cal_start (cal_start)
    );

    synth_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_hit     (wr_hit),
        .rd_en      (rd_en),
        .rd_hit     (in_range),
        .idx        (idx),
        .wdata      (wdata),
        .cal_fire   (cal_fire),
        .fdiv_ratio (fdiv_ratio),
        .ref_div    (ref_div),
        .ctrl       (ctrl),
        .rdata      (rdata)
    );

    synth_lock_gate #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .lock_in  (lock_in),
        .force_rf (force_w),
        .rf_en    (rf_en)
    );
endmodule

// File: rtl/synth_cfg_checker.sv
`timescale 1ns/1ps
module synth_cfg_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              cal_start,
    input logic [9:0]        fdiv_ratio,
    input logic [4:0]        ref_div,
    input logic [1:0]        buf_cur,
    input logic              rf_en,
    input logic              cal_mode,
    input logic              force_rf
);
    a_r6_lo_write_cal: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(0)) |=> cal_start);

    a_r7_rdiv_write_cal: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(2) && cal_mode) |=> cal_start);

    a_r6_rdiv_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(2) && !cal_mode) |=> !cal_start);

    a_r8_idle_no_cal: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !cal_start);

    a_r8_hi_write_no_cal: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == ADDR_W'(1) || addr == ADDR_W'(3))) |=> !cal_start);

    a_r5_hi_write_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(1)) |=> $stable(fdiv_ratio));

    a_r3_oob_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr > ADDR_W'(3)) |=>
            ($stable(fdiv_ratio) && $stable(ref_div) && $stable(buf_cur) && !cal_start));

    a_r10_force_on: assert property (@(posedge clk) disable iff (rst)
        force_rf |-> rf_en);
endmodule

bind synth_cfg_bank synth_cfg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .cal_start  (cal_start),
    .fdiv_ratio (fdiv_ratio),
    .ref_div    (ref_div),
    .buf_cur    (buf_cur),
    .rf_en      (rf_en),
    .cal_mode   (cal_mode_w),
    .force_rf   (force_w)
);

// File: tb/synth_cfg_bank_bench.sv
`timescale 1ns/1ps
module synth_cfg_bank_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       lock_in = 1'b0;
    logic [7:0] rdata;
    logic [9:0] fdiv_ratio;
    logic [4:0] ref_div;
    logic [1:0] buf_cur;
    logic       cal_start;
    logic       rf_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    synth_cfg_bank u_synth_cfg_bank (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .wdata      (wdata),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rdata      (rdata),
        .lock_in    (lock_in),
        .fdiv_ratio (fdiv_ratio),
        .ref_div    (ref_div),
        .buf_cur    (buf_cur),
        .cal_start  (cal_start),
        .rf_en      (rf_en)
    );

    // {addr, write data, expected readback, expected cal pulse}
    localparam logic [24:0] VEC [8] = '{
        {8'h00, 8'hA5, 8'hA5, 1'b1},
        {8'h01, 8'hFF, 8'h03, 1'b0},
        {8'h02, 8'hFF, 8'h1F, 1'b0},
        {8'h03, 8'hF0, 8'h00, 1'b0},
        {8'h03, 8'hFF, 8'h0F, 1'b0},
        {8'h04, 8'hFF, 8'h00, 1'b0},
        {8'hFF, 8'h55, 8'h00, 1'b0},
        {8'h03, 8'h03, 8'h03, 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, output logic cal);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        cal = cal_start;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic       c;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 fdiv", 16'(fdiv_ratio), 16'h0);
        check("R1 ref_div/buf_cur", 16'({ref_div, buf_cur}), 16'h0);
        check("R1 cal/rf/rdata", 16'({cal_start, rf_en, rdata}), 16'h0);
        rd(8'h03, v);
        check("R1 ctrl readback", 16'(v), 16'h0);

        // R2 R3 vector walk: write, cal pulse, readback
        for (int i = 0; i < 8; i++) begin
            logic [7:0] va, vd, ve;
            logic       vc;
            {va, vd, ve, vc} = VEC[i];
            wr(va, vd, c);
            check("R2/R3/R8 cal on vector write", 16'(c), 16'(vc));
            rd(va, v);
            check("R2/R3 readback", 16'(v), 16'(ve));
        end

        // R5 staged high bits not applied yet; R4 fields
        check("R5 fdiv before apply", 16'(fdiv_ratio), 16'h0A5);
        check("R4 ref_div", 16'(ref_div), 16'h1F);
        check("R4 buf_cur", 16'(buf_cur), 16'h3);

        // R6 low-byte write applies staged bits, one-cycle pulse
        wr(8'h00, 8'h12, c);
        check("R6 cal on lo write", 16'(c), 16'h1);
        check("R5 fdiv applied", 16'(fdiv_ratio), 16'h312);
        @(negedge clk);
        check("R6 pulse one cycle", 16'(cal_start), 16'h0);

        // R8 read gives no pulse
        rd(8'h00, v);
        check("R8 read no cal", 16'(cal_start), 16'h0);

        // R5 R8 hi write holds divider
        wr(8'h01, 8'h01, c);
        check("R8 hi write no cal", 16'(c), 16'h0);
        check("R5 fdiv held", 16'(fdiv_ratio), 16'h312);

        // R6 mode 0: rdiv write no cal
        wr(8'h02, 8'h09, c);
        check("R6 rdiv write mode0 no cal", 16'(c), 16'h0);
        check("R6 fdiv unchanged", 16'(fdiv_ratio), 16'h312);

        // R7 mode 1: rdiv write cal and applies staged bits
        wr(8'h03, 8'h04, c);
        check("R8 ctrl write no cal", 16'(c), 16'h0);
        wr(8'h02, 8'h07, c);
        check("R7 rdiv write mode1 cal", 16'(c), 16'h1);
        check("R7 fdiv applied via rdiv", 16'(fdiv_ratio), 16'h112);
        check("R4 ref_div updated", 16'(ref_div), 16'h07);
        wr(8'h03, 8'h00, c);

        // R9 lock synchronizer
        lock_in = 1'b1;
        @(negedge clk);
        check("R9 rf_en after one edge", 16'(rf_en), 16'h0);
        @(negedge clk);
        check("R9 rf_en after two edges", 16'(rf_en), 16'h1);
        lock_in = 1'b0;
        @(negedge clk);
        check("R9 rf_en holds one edge", 16'(rf_en), 16'h1);
        @(negedge clk);
        check("R9 rf_en drops", 16'(rf_en), 16'h0);

        // R10 force
        wr(8'h03, 8'h08, c);
        check("R10 forced without lock", 16'(rf_en), 16'h1);
        repeat (3) @(negedge clk);
        check("R10 still forced", 16'(rf_en), 16'h1);

        // R1 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset fdiv", 16'(fdiv_ratio), 16'h0);
        check("R1 reset rf/ref", 16'({rf_en, ref_div}), 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule